// File: doc/BRIEF.md
# Special-Opcode Integer Extension ALU

This block executes a small family of extension integer instructions that all share the special major opcode `011100` in bits 31:26 of a 32-bit instruction word. The surrounding core supplies the instruction and the two 64-bit source values, already read from its register file for the rs field (bits 25:21) and the rt field (bits 20:16). One clock edge later the block returns a destination register index, a write enable and a 64-bit result. A separate flag reports a word that carries the special major opcode but matches none of the supported patterns.

The supported operations are:
- a byte-wide sum of the two sources with all upper bits cleared;
- the low 64 bits of their product;
- a population count over either 32 or 64 bits of rs;
- an equal or not-equal test between rs and rt;
- an equal or not-equal test between rs and a sign-extended 10-bit immediate.

Writes aimed at register 0 are suppressed. Words with any other major opcode are not this block's business: it neither writes nor flags them.

Top module: `xop_alu`

## Requirements
- R1: Each cycle with `valid_i` high produces exactly one cycle with `valid_o` high, on the clock edge immediately following. Results come out in issue order, and back-to-back inputs are accepted every cycle.
- R2: Byte add is major `011100`, bits 10:6 = `00000` and bits 5:0 = `101000`. It writes index rd (bits 15:11) with (rs + rt) mod 256, and bits 63:8 of the result are zero.
- R3: Multiply is major `011100`, bits 10:6 = `00000` and bits 5:0 = `000011`. It writes rd with the low 64 bits of rs × rt.
- R4: Population count is major `011100`, bits 5:1 = `10110`, rt = 0 and bits 10:6 = 0. It writes rd with the number of set bits in rs: all 64 bits when bit 0 = 1, and only bits 31:0 when bit 0 = 0. The count is zero-extended.
- R5: Register compare is major `011100`, bits 5:1 = `10101` and bits 10:6 = 0. With bit 0 = 0 it writes rd with 1 if rs equals rt and 0 otherwise. With bit 0 = 1 it writes 1 if they differ. All other result bits are zero.
- R6: Immediate compare is major `011100` and bits 5:1 = `10111`. It treats bits 15:6 as a signed 10-bit immediate, sign-extends it to 64 bits and compares it with rs, with bit 0 selecting equal (0) or not-equal (1). It writes a 0/1 result to index rt (bits 20:16), not rd.
- R7: A recognised instruction whose destination index is 0 gives `wr_en_o` = 0 and `illegal_o` = 0.
- R8: A word with major `011100` that matches none of the patterns in R2 to R6 gives `illegal_o` = 1 and `wr_en_o` = 0. This covers a nonzero bits 10:6 where zero is required and a nonzero rt on population count.
- R9: A word whose bits 31:26 are not `011100` gives `wr_en_o` = 0 and `illegal_o` = 0.
- R10: In a cycle following one without `valid_i`, the outputs `valid_o`, `wr_en_o` and `illegal_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction and operands are present this cycle |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | Value of register rs |
| rt_val_i | input | 64 | Value of register rt |
| valid_o | output | 1 | Registered result slot is occupied |
| wr_en_o | output | 1 | Write `result_o` to register `wr_idx_o` |
| wr_idx_o | output | 5 | Destination register index |
| result_o | output | 64 | Operation result |
| illegal_o | output | 1 | Special-opcode word not recognised |

## Verification
Every result, flag and index is due on the first rising edge after the input cycle, so the outcome of an instruction driven in cycle N is visible during cycle N+1. The driver tags each expected item with the cycle in which it was issued. The monitor samples on the falling edge and rejects any output whose cycle is not exactly one after its tag. Instructions are issued back to back as well as separated by idle cycles, and during idle cycles the monitor checks that the valid, write and illegal outputs stay low.

// File: rtl/xop_alu_pkg.sv
package xop_alu_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned IMM_W   = 10;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned CNT_W   = $clog2(DATA_W + 1);
  localparam logic [5:0]  MAJOR   = 6'b011100;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_BADD = 3'd1,
    K_MUL  = 3'd2,
    K_POP  = 3'd3,
    K_CMPR = 3'd4,
    K_CMPI = 3'd5
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic             alt;      // pop: full width / cmp: not-equal
    logic [IDX_W-1:0] dest;
    logic             wr;
    logic             illegal;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/xop_alu_decode.sv
module xop_alu_decode
  import xop_alu_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic [5:0]       major;
  logic [IDX_W-1:0] f_rt, f_rd;
  logic [4:0]       f_sa;
  logic [5:0]       f_fn;
  logic             sa_zero;
  logic             unused_rs;

  assign major     = instr_i[31:26];
  assign f_rt      = instr_i[20:16];
  assign f_rd      = instr_i[15:11];
  assign f_sa      = instr_i[10:6];
  assign f_fn      = instr_i[5:0];
  assign sa_zero   = (f_sa == 5'd0);
  assign unused_rs = ^instr_i[25:21];

  always_comb begin
    dec_o.kind    = K_NONE;
    dec_o.alt     = f_fn[0];
    dec_o.dest    = f_rd;
    dec_o.imm     = instr_i[15:6];
    if (major == MAJOR) begin
      if (sa_zero && f_fn == 6'b101000)                         dec_o.kind = K_BADD;
      else if (sa_zero && f_fn == 6'b000011)                    dec_o.kind = K_MUL;
      else if (sa_zero && f_rt == '0 && f_fn[5:1] == 5'b10110)  dec_o.kind = K_POP;
      else if (sa_zero && f_fn[5:1] == 5'b10101)                dec_o.kind = K_CMPR;
      else if (f_fn[5:1] == 5'b10111) begin
        dec_o.kind = K_CMPI;
        dec_o.dest = f_rt;
      end
    end
    dec_o.illegal = (major == MAJOR) && (dec_o.kind == K_NONE);
    dec_o.wr      = (dec_o.kind != K_NONE) && (dec_o.dest != '0);
  end
endmodule

// File: rtl/xop_alu_popcnt.sv
module xop_alu_popcnt #(
  parameter int unsigned W     = 64,
  parameter int unsigned OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     val_i,
  output logic [OUT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + OUT_W'(val_i[i]);
  end
endmodule

// File: rtl/xop_alu_exec.sv
module xop_alu_exec
  import xop_alu_pkg::*;
(
  input  kind_e             kind_i,
  input  logic              alt_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] imm_ext, pop_in, cmp_rhs;
  logic [CNT_W-1:0]  pop_cnt;
  logic [7:0]        byte_sum;
  logic              same;

  assign imm_ext  = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign pop_in   = alt_i ? rs_i : {{(DATA_W-HALF_W){1'b0}}, rs_i[HALF_W-1:0]};
  assign cmp_rhs  = (kind_i == K_CMPI) ? imm_ext : rt_i;
  assign same     = (rs_i == cmp_rhs);
  assign byte_sum = rs_i[7:0] + rt_i[7:0];

  xop_alu_popcnt #(.W(DATA_W), .OUT_W(CNT_W)) u_popcnt (
    .val_i (pop_in),
    .cnt_o (pop_cnt)
  );

  always_comb begin
    unique case (kind_i)
      K_BADD:         res_o = {{(DATA_W-8){1'b0}}, byte_sum};
      K_MUL:          res_o = rs_i * rt_i;
      K_POP:          res_o = {{(DATA_W-CNT_W){1'b0}}, pop_cnt};
      K_CMPR, K_CMPI: res_o = {{(DATA_W-1){1'b0}}, same ^ alt_i};
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/xop_alu.sv
module xop_alu
  import xop_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  dec_t              dec;
  logic [DATA_W-1:0] res_d;
  kind_e             q_kind;

  xop_alu_decode u_decode (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  xop_alu_exec u_exec (
    .kind_i (dec.kind),
    .alt_i  (dec.alt),
    .imm_i  (dec.imm),
    .rs_i   (rs_val_i),
    .rt_i   (rt_val_i),
    .res_o  (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      wr_idx_o  <= '0;
      result_o  <= '0;
      q_kind    <= K_NONE;
    end else begin
      valid_o   <= valid_i;
      wr_en_o   <= valid_i & dec.wr;
      illegal_o <= valid_i & dec.illegal;
      if (valid_i) begin
        wr_idx_o <= dec.dest;
        result_o <= res_d;
        q_kind   <= dec.kind;
      end
    end
  end

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !wr_en_o && !illegal_o); // R10
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && q_kind == K_BADD) |-> result_o[DATA_W-1:8] == '0); // R2
  AST_POP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && q_kind == K_POP) |-> result_o <= DATA_W); // R4
  AST_CMP_BOOLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && (q_kind == K_CMPR || q_kind == K_CMPI)) |-> result_o[DATA_W-1:1] == '0); // R5
  AST_NO_ZERO_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_idx_o != '0); // R7
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en_o && valid_o); // R8
endmodule

// File: tb/xop_alu_bench.sv
module xop_alu_bench;
  localparam time HALF = 10ns;

  typedef struct {
    int          stamp;
    logic        wr;
    logic [4:0]  idx;
    logic [63:0] res;
    logic        ill;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] a = '0, b = '0;
  logic        valid_o, wr_en_o, illegal_o;
  logic [4:0]  wr_idx_o;
  logic [63:0] result_o;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  exp_t sb[$];

  always #HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xop_alu u_xop_alu (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .rs_val_i(a), .rt_val_i(b), .valid_o(valid_o), .wr_en_o(wr_en_o),
    .wr_idx_o(wr_idx_o), .result_o(result_o), .illegal_o(illegal_o)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, sa, input logic [5:0] fn);
    return {6'b011100, rs, rt, rd, sa, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [4:0] rs, rt, input logic [9:0] imm, input logic ne);
    return {6'b011100, rs, rt, imm, 5'b10111, ne};
  endfunction

  task automatic send(input string tag, input logic [31:0] ins, input logic [63:0] va, vb,
                      input logic ewr, input logic [4:0] eidx, input logic [63:0] eres,
                      input logic eill);
    exp_t e;
    @(negedge clk);
    instr = ins; a = va; b = vb; valid = 1'b1;
    e.stamp = cyc; e.wr = ewr; e.idx = eidx; e.res = eres; e.ill = eill; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
      instr = $urandom; a = {$urandom, $urandom}; b = {$urandom, $urandom};
    end
  endtask

  // monitor: compare results one cycle after issue
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R1 valid_o with no pending item (actual 1 expected 0)");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (cyc != e.stamp + 1) begin
            errors++;
            $display("FAIL R1 %s latency actual %0d expected 1", e.tag, cyc - e.stamp);
          end else if (wr_en_o !== e.wr || illegal_o !== e.ill) begin
            errors++;
            $display("FAIL %s wr/ill actual %b/%b expected %b/%b", e.tag, wr_en_o, illegal_o, e.wr, e.ill);
          end else if (e.wr && (wr_idx_o !== e.idx || result_o !== e.res)) begin
            errors++;
            $display("FAIL %s idx/res actual %0d/%h expected %0d/%h", e.tag, wr_idx_o, result_o, e.idx, e.res);
          end
        end
      end else begin
        checks++; // R10 quiet outputs when idle
        if (wr_en_o || illegal_o) begin
          errors++;
          $display("FAIL R10 idle wr/ill actual %b/%b expected 0/0", wr_en_o, illegal_o);
        end
      end
    end
  end

  initial begin
    #(HALF * 2 * 100000);
    errors++;
    $display("FAIL watchdog expired (actual hung, expected completion)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] m1, m2;
    m1 = 64'h0000_0001_0000_0001;
    m2 = 64'h0000_0002_0000_0003;
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o || wr_en_o || illegal_o || result_o != '0) begin
      errors++;
      $display("FAIL R1 reset state actual %b%b%b expected 000", valid_o, wr_en_o, illegal_o);
    end
    rst_n = 1'b1;
    idle(2);

    // R2 byte add
    send("R2 carry out of byte", enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b101000),
         64'h0000_0000_0000_00F0, 64'h1234_0000_0000_0025, 1, 5'd3, 64'h15, 0);
    send("R2 all ones plus one", enc_r(5'd4, 5'd5, 5'd31, 5'd0, 6'b101000),
         '1, 64'd1, 1, 5'd31, 64'h0, 0);
    // R3 multiply
    send("R3 minus one times three", enc_r(5'd1, 5'd2, 5'd9, 5'd0, 6'b000011),
         '1, 64'd3, 1, 5'd9, 64'hFFFF_FFFF_FFFF_FFFD, 0);
    send("R3 wide product", enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'b000011),
         m1, m2, 1, 5'd10, m1 * m2, 0);
    idle(1);
    // R4 popcount
    send("R4 wide all ones", enc_r(5'd6, 5'd0, 5'd12, 5'd0, 6'b101101), '1, 64'hDEAD, 1, 5'd12, 64'd64, 0);
    send("R4 narrow all ones", enc_r(5'd6, 5'd0, 5'd12, 5'd0, 6'b101100), '1, 64'hDEAD, 1, 5'd12, 64'd32, 0);
    send("R4 wide pattern", enc_r(5'd6, 5'd0, 5'd13, 5'd0, 6'b101101), 64'hF0F0_0000_8000_0001, 0, 1, 5'd13,
         64'($countones(64'hF0F0_0000_8000_0001)), 0);
    send("R4 narrow ignores upper", enc_r(5'd6, 5'd0, 5'd13, 5'd0, 6'b101100), 64'hFFFF_FFFF_0000_0101, 0,
         1, 5'd13, 64'd2, 0);
    // R5 register compare
    send("R5 eq same", enc_r(5'd1, 5'd2, 5'd14, 5'd0, 6'b101010), 64'h55AA, 64'h55AA, 1, 5'd14, 64'd1, 0);
    send("R5 ne same", enc_r(5'd1, 5'd2, 5'd14, 5'd0, 6'b101011), 64'h55AA, 64'h55AA, 1, 5'd14, 64'd0, 0);
    send("R5 eq differ", enc_r(5'd1, 5'd2, 5'd15, 5'd0, 6'b101010), 64'h8000_0000_0000_0000, 0, 1, 5'd15, 64'd0, 0);
    send("R5 ne differ", enc_r(5'd1, 5'd2, 5'd15, 5'd0, 6'b101011), 64'h8000_0000_0000_0000, 0, 1, 5'd15, 64'd1, 0);
    idle(2);
    // R6 immediate compare, destination rt
    send("R6 eq minus one", enc_i(5'd3, 5'd7, 10'h3FF, 0), '1, 0, 1, 5'd7, 64'd1, 0);
    send("R6 ne equal five", enc_i(5'd3, 5'd8, 10'd5, 1), 64'd5, 0, 1, 5'd8, 64'd0, 0);
    send("R6 eq most negative", enc_i(5'd3, 5'd9, 10'h200, 0), 64'hFFFF_FFFF_FFFF_FE00, 0, 1, 5'd9, 64'd1, 0);
    send("R6 sign extension", enc_i(5'd3, 5'd9, 10'h3FF, 0), 64'h3FF, 0, 1, 5'd9, 64'd0, 0);
    // R7 destination zero
    send("R7 byte add rd0", enc_r(5'd1, 5'd2, 5'd0, 5'd0, 6'b101000), 64'd1, 64'd2, 0, 5'd0, 0, 0);
    send("R7 imm cmp rt0", enc_i(5'd3, 5'd0, 10'd1, 1), 64'd0, 0, 0, 5'd0, 0, 0);
    // R8 illegal patterns
    send("R8 nonzero shift field", enc_r(5'd1, 5'd2, 5'd3, 5'd1, 6'b101000), 0, 0, 0, 5'd0, 0, 1);
    send("R8 pop with rt", enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b101101), 0, 0, 0, 5'd0, 0, 1);
    send("R8 unknown funct", enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b111111), 0, 0, 0, 5'd0, 0, 1);
    // R9 foreign major opcode
    send("R9 other major", {6'b000000, 5'd1, 5'd2, 5'd3, 5'd0, 6'b101000}, 64'd1, 64'd1, 0, 5'd0, 0, 0);
    idle(4);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results actual %0d pending expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule